// File: doc/BRIEF.md
# Stimulus Playback and Capture Engine

This block replays stored test patterns into a device under test and stores what the device sends back. A host uses a small local-bus interface for three things: filling the stimulus and trigger memories, writing a start address and a word count, and writing a start bit. The engine then reads one word per channel on every clock, beginning at the start address. It drives those words on twenty-five 16-bit channels, which form five groups of five.

A one-bit trigger memory is read at the same address on the same cycle. A set bit there raises a trigger pulse that travels with that stimulus word. While the sequence is playing, each of six 17-bit return links is captured into its own record memory. A link is captured only on cycles when its handshake bit is set. The host reads back the record memories, a word count for each link, and a status word.

The memory depth is set by `ADDR_W` (2^ADDR_W words). Using `ADDR_W = 16` gives the full 64k-word space. The smaller default keeps the internal arrays small.

Top module: `stimEngine`

## Requirements
- R1: After reset, `busy`, `done`, `stimValid` and `trigOut` are 0 and every link word counter reads 0.
- R2: The bus address is `{region[1:0], select[CH_W-1:0], word[ADDR_W-1:0]}`, with region 0 = registers, 1 = stimulus memory (select = channel), 2 = trigger memory (data bit 0), and 3 = record memory (select = link, read only). The register index is the low 4 bits of `word`: 0 = start address, 1 = length, 2 = control/status, and 8+n = word counter of link n. Registers 0 and 1 read back the value last written.
- R3: Writing register 2 with data bit 0 set while idle launches a sequence, and `busy` is 1 from the next cycle. On each busy cycle one address is read, starting at the start address and incrementing by one. The words from that address appear on `stimOut` one cycle later, with `stimValid` = 1.
- R4: A sequence of length L > 0 produces exactly L valid words. `busy` falls and `done` rises in the same cycle that the last word appears. `done` stays set until the next launch. `busy` and `done` are never set together.
- R5: A length of 0 produces no words and sets `done` in the cycle after the start write.
- R6: The address wraps from 2^ADDR_W-1 to 0 when the length is not yet used up.
- R7: A start write while `busy` is 1 has no effect: the running word sequence and the link counters continue unchanged.
- R8: `trigOut` is 1 in exactly those cycles that carry a valid word whose trigger-memory bit is 1.
- R9: Channel c (group c/5, position c%5) occupies `stimOut[16c +: 16]`.
- R10: On every busy cycle, each link whose bit 16 (the handshake) is 1 has all 17 bits stored in its record memory at address count mod 2^ADDR_W, and its count then increments. Counts clear on launch.
- R11: Reading register 2 returns `done` in bit 1 and `busy` in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Bus write strobe |
| busAddr | input | 2+CH_W+ADDR_W | Bus address |
| busWData | input | DATA_W | Bus write data |
| busRData | output | DATA_W+1 | Combinational bus read data |
| linkIn | input | NUM_LINKS*(DATA_W+1) | Return links, link n at bits [17n +: 17] |
| stimOut | output | NUM_CH*DATA_W | Stimulus channels |
| stimValid | output | 1 | stimOut carries a sequence word |
| trigOut | output | 1 | Trigger pulse to the device |
| busy | output | 1 | Sequence running |
| done | output | 1 | Last sequence finished |

## Verification
The main function is tried with these input patterns:

- **Short run in the middle of memory:** separates correct start-address loading from an offset.
- **Run that crosses the top address:** exposes a missing or wrong wrap.
- **Run longer than the memory depth:** shows the wrap repeating and the record pointer wrapping.
- **Zero-length run:** separates an immediate `done` from a stray word.
- **Start re-issued during a run:** shows whether a restart or a counter clear leaks through.

Random handshake patterns on the links make each per-link count differ. That distinguishes per-link capture from shared capture.

// File: rtl/stimPkg.sv
package stimPkg;
  typedef struct packed {
    logic launch;
    logic step;
  } seqStrobe_t;

  localparam logic [1:0] REGION_CSR  = 2'd0;
  localparam logic [1:0] REGION_STIM = 2'd1;
  localparam logic [1:0] REGION_TRIG = 2'd2;
  localparam logic [1:0] REGION_REC  = 2'd3;

  localparam logic [3:0] CSR_BASE = 4'd0;
  localparam logic [3:0] CSR_LEN  = 4'd1;
  localparam logic [3:0] CSR_CTRL = 4'd2;
  localparam logic [3:0] CSR_CNT0 = 4'd8;
endpackage

// File: rtl/stimCtrl.sv
module stimCtrl
  import stimPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 16,
  parameter int BUS_AW = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic [ADDR_W-1:0] startAddr,
  output logic [DATA_W-1:0] csrRData,
  output seqStrobe_t        strobes,
  output logic              busy,
  output logic              done
);
  logic [LEN_W-1:0] seqLen;
  logic [LEN_W-1:0] remaining;
  logic [1:0]       region;
  logic [3:0]       regIdx;
  logic             csrWr;
  logic             launch;

  assign region = busAddr[BUS_AW-1 -: 2];
  assign regIdx = busAddr[3:0];
  assign csrWr  = busWr && (region == REGION_CSR);
  assign launch = csrWr && (regIdx == CSR_CTRL) && busWData[0] && !busy;

  assign strobes.launch = launch;
  assign strobes.step   = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      seqLen    <= '0;
      remaining <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (csrWr && regIdx == CSR_BASE) startAddr <= busWData[ADDR_W-1:0];
      if (csrWr && regIdx == CSR_LEN)  seqLen    <= busWData[LEN_W-1:0];
      if (launch) begin
        done      <= (seqLen == '0);
        busy      <= (seqLen != '0);
        remaining <= seqLen;
      end else if (busy) begin
        remaining <= remaining - LEN_W'(1);
        if (remaining == LEN_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (regIdx)
      CSR_BASE: csrRData = DATA_W'(startAddr);
      CSR_LEN:  csrRData = DATA_W'(seqLen);
      CSR_CTRL: csrRData = DATA_W'({done, busy});
      default:  csrRData = '0;
    endcase
  end
endmodule

// File: rtl/stimDatapath.sv
module stimDatapath
  import stimPkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_CH    = 25,
  parameter int NUM_LINKS = 6,
  parameter int ADDR_W    = 6,
  parameter int CNT_W     = 16,
  parameter int CH_W      = 5,
  parameter int BUS_AW    = 13
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWr,
  input  logic [BUS_AW-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWData,
  input  logic [ADDR_W-1:0]             startAddr,
  input  seqStrobe_t                    strobes,
  input  logic [NUM_LINKS*(DATA_W+1)-1:0] linkIn,
  output logic [NUM_CH*DATA_W-1:0]      stimOut,
  output logic                          stimValid,
  output logic                          trigOut,
  output logic [DATA_W:0]               dpRData
);
  localparam int DEPTH  = 2 ** ADDR_W;
  localparam int LINK_W = DATA_W + 1;
  localparam int LK_W   = $clog2(NUM_LINKS);

  logic [1:0]        region;
  logic [CH_W-1:0]   sel;
  logic [ADDR_W-1:0] word;
  logic [3:0]        regIdx;
  logic [3:0]        cntOff;
  logic [ADDR_W-1:0] addrCnt;
  logic              trigMem [DEPTH];
  logic [LINK_W-1:0] recRd  [NUM_LINKS];
  logic [CNT_W-1:0]  cntArr [NUM_LINKS];

  assign region = busAddr[BUS_AW-1 -: 2];
  assign sel    = busAddr[ADDR_W +: CH_W];
  assign word   = busAddr[ADDR_W-1:0];
  assign regIdx = busAddr[3:0];
  assign cntOff = regIdx - CSR_CNT0;

  // Shared playback address: loads on launch, advances one per busy cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt   <= '0;
      stimValid <= 1'b0;
      trigOut   <= 1'b0;
    end else begin
      if (strobes.launch)    addrCnt <= startAddr;
      else if (strobes.step) addrCnt <= addrCnt + ADDR_W'(1);
      stimValid <= strobes.step;
      trigOut   <= strobes.step && trigMem[addrCnt];
    end
  end

  always_ff @(posedge clk) begin
    if (busWr && region == REGION_TRIG) trigMem[word] <= busWData[0];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] outReg;
    always_ff @(posedge clk) begin
      if (busWr && region == REGION_STIM && sel == CH_W'(ch)) mem[word] <= busWData;
    end
    always_ff @(posedge clk) begin
      if (!rstN)             outReg <= '0;
      else if (strobes.step) outReg <= mem[addrCnt];
    end
    assign stimOut[ch*DATA_W +: DATA_W] = outReg;
  end

  for (genvar lk = 0; lk < NUM_LINKS; lk++) begin : g_link
    logic [LINK_W-1:0] mem [DEPTH];
    logic [LINK_W-1:0] linkWord;
    logic [CNT_W-1:0]  cnt;
    assign linkWord = linkIn[lk*LINK_W +: LINK_W];
    always_ff @(posedge clk) begin
      if (!rstN)                                  cnt <= '0;
      else if (strobes.launch)                    cnt <= '0;
      else if (strobes.step && linkWord[DATA_W])  cnt <= cnt + CNT_W'(1);
    end
    always_ff @(posedge clk) begin
      if (strobes.step && linkWord[DATA_W]) mem[cnt[ADDR_W-1:0]] <= linkWord;
    end
    assign recRd[lk]  = mem[word];
    assign cntArr[lk] = cnt;
  end

  always_comb begin
    dpRData = '0;
    if (region == REGION_REC && int'(sel) < NUM_LINKS)
      dpRData = recRd[sel[LK_W-1:0]];
    else if (region == REGION_CSR && regIdx >= CSR_CNT0 && int'(cntOff) < NUM_LINKS)
      dpRData = LINK_W'(cntArr[cntOff[LK_W-1:0]]);
  end
endmodule

// File: rtl/stimEngine.sv
module stimEngine
  import stimPkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int NUM_GROUPS    = 5,
  parameter int CH_PER_GROUP  = 5,
  parameter int NUM_LINKS     = 6,
  parameter int ADDR_W        = 6,
  parameter int LEN_W         = 16,
  parameter int CNT_W         = 16,
  localparam int NUM_CH       = NUM_GROUPS * CH_PER_GROUP,
  localparam int CH_W         = $clog2(NUM_CH),
  localparam int BUS_AW       = 2 + CH_W + ADDR_W,
  localparam int LINK_W       = DATA_W + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busWr,
  input  logic [BUS_AW-1:0]           busAddr,
  input  logic [DATA_W-1:0]           busWData,
  output logic [LINK_W-1:0]           busRData,
  input  logic [NUM_LINKS*LINK_W-1:0] linkIn,
  output logic [NUM_CH*DATA_W-1:0]    stimOut,
  output logic                        stimValid,
  output logic                        trigOut,
  output logic                        busy,
  output logic                        done
);
  seqStrobe_t        strobes;
  logic [ADDR_W-1:0] startAddr;
  logic [DATA_W-1:0] csrRData;
  logic [LINK_W-1:0] dpRData;

  stimCtrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_AW(BUS_AW)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWData(busWData),
    .startAddr(startAddr), .csrRData(csrRData), .strobes(strobes), .busy(busy), .done(done)
  );

  stimDatapath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .NUM_LINKS(NUM_LINKS), .ADDR_W(ADDR_W),
                 .CNT_W(CNT_W), .CH_W(CH_W), .BUS_AW(BUS_AW)) i_dp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWData(busWData),
    .startAddr(startAddr), .strobes(strobes), .linkIn(linkIn), .stimOut(stimOut),
    .stimValid(stimValid), .trigOut(trigOut), .dpRData(dpRData)
  );

  assign busRData = (busAddr[BUS_AW-1 -: 2] == REGION_CSR && busAddr[3:0] < CSR_CNT0)
                    ? {1'b0, csrRData} : dpRData;
endmodule

// File: rtl/stimEngineChk.sv
module stimEngineChk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic stimValid,
  input logic trigOut
);
  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(busy && done));
  // R3
  valid_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stimValid |-> $past(busy));
  // R8
  trig_with_word_chk: assert property (@(posedge clk) disable iff (!rstN) trigOut |-> stimValid);
  // R4
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done);
  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !busy) |=> (done || busy));
endmodule

bind stimEngine stimEngineChk i_stimEngineChk (.*);

// File: tb/test_stimEngine.sv
module test_stimEngine;
  localparam int NCH = 25, NL = 6, DEPTH = 64, AW = 13;

  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [15:0] busWData = '0;
  logic [16:0] busRData;
  logic [NL*17-1:0] linkIn = '0;
  logic [NCH*16-1:0] stimOut;
  logic stimValid, trigOut, busy, done;

  stimEngine i_stimEngine (.*);

  always #2 clk = ~clk;

  int vectors = 0, fails = 0;
  string curReq = "R3";
  bit linkEn = 0;

  // behavioural reference model
  int stimModel [NCH][DEPTH];
  bit trigModel [DEPTH];
  int recModel [NL][DEPTH];
  int cntModel [NL];
  int q[$];
  int mStart = 0, mLen = 0, expAddr = 0;
  bit mBusy = 0, mDone = 0, expValid = 0, wasBusy;

  function automatic logic [AW-1:0] mkAddr(int region, int sel, int word);
    return {region[1:0], sel[4:0], word[5:0]};
  endfunction

  task automatic chk(string req, logic [399:0] act, logic [399:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      wasBusy = mBusy;
      expValid = 0;
      if (wasBusy) begin
        expAddr = q.pop_front();
        expValid = 1;
        for (int l = 0; l < NL; l++)
          if (linkIn[l*17+16]) begin
            recModel[l][cntModel[l] % DEPTH] = int'(linkIn[l*17 +: 17]);
            cntModel[l]++;
          end
        if (q.size() == 0) begin mBusy = 0; mDone = 1; end
      end
      if (busWr && busAddr[12:11] == 2'd0) begin
        if (busAddr[3:0] == 4'd0) mStart = int'(busWData[5:0]);
        if (busAddr[3:0] == 4'd1) mLen = int'(busWData);
        if (busAddr[3:0] == 4'd2 && busWData[0] && !wasBusy) begin
          q.delete();
          for (int k = 0; k < mLen; k++) q.push_back((mStart + k) % DEPTH);
          mDone = (mLen == 0);
          mBusy = (mLen > 0);
          for (int l = 0; l < NL; l++) cntModel[l] = 0;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic [399:0] ev;
      ev = '0;
      chk({curReq, " R4 busy"}, 400'(busy), 400'(mBusy));
      chk({curReq, " R4 done"}, 400'(done), 400'(mDone));
      chk({curReq, " R3 valid"}, 400'(stimValid), 400'(expValid));
      chk({curReq, " R8 trig"}, 400'(trigOut), 400'(expValid && trigModel[expAddr]));
      if (expValid) begin
        for (int c = 0; c < NCH; c++) ev[c*16 +: 16] = 16'(stimModel[c][expAddr]);
        chk({curReq, " R9 words"}, 400'(stimOut), ev);
      end
    end
    if (linkEn) linkIn = {$urandom(), $urandom(), $urandom(), $urandom()};
    else linkIn = '0;
  end

  task automatic busWrite(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk); busWr = 1; busAddr = a; busWData = d;
    @(negedge clk); busWr = 0;
  endtask

  task automatic busRead(logic [AW-1:0] a, output logic [16:0] d);
    @(negedge clk); busAddr = a; #1; d = busRData;
  endtask

  task automatic runSeq(int start, int len, int restartAfter);
    busWrite(mkAddr(0, 0, 0), 16'(start));
    busWrite(mkAddr(0, 0, 1), 16'(len));
    busWrite(mkAddr(0, 0, 2), 16'd1);
    if (restartAfter > 0) begin
      repeat (restartAfter) @(negedge clk);
      busWrite(mkAddr(0, 0, 2), 16'd1);  // R7: ignored while busy
    end
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkRecords(string req);
    logic [16:0] d;
    for (int l = 0; l < NL; l++) begin
      busRead(mkAddr(0, 0, 8 + l), d);
      chk({req, " R10 count"}, 400'(d), 400'(cntModel[l]));
      for (int i = 0; i < DEPTH && i < cntModel[l]; i++) begin
        busRead(mkAddr(3, l, i), d);
        chk({req, " R10 record"}, 400'(d), 400'(recModel[l][i]));
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [16:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    @(negedge clk);
    chk("R1 busy", 400'(busy), 400'(0));
    chk("R1 done", 400'(done), 400'(0));
    chk("R1 valid", 400'(stimValid), 400'(0));
    chk("R1 trig", 400'(trigOut), 400'(0));
    for (int l = 0; l < NL; l++) begin
      busRead(mkAddr(0, 0, 8 + l), d);
      chk("R1 count", 400'(d), 400'(0));
    end
    // R2: memory and register load
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < DEPTH; w++) begin
        stimModel[c][w] = (c * 4099 + w * 77 + 13) & 16'hFFFF;
        busWrite(mkAddr(1, c, w), 16'(stimModel[c][w]));
      end
    for (int w = 0; w < DEPTH; w++) begin
      trigModel[w] = (w % 3 == 0);
      busWrite(mkAddr(2, 0, w), 16'(trigModel[w]));
    end
    busWrite(mkAddr(0, 0, 0), 16'd37);
    busWrite(mkAddr(0, 0, 1), 16'd1234);
    busRead(mkAddr(0, 0, 0), d); chk("R2 start reg", 400'(d), 400'(37));
    busRead(mkAddr(0, 0, 1), d); chk("R2 len reg", 400'(d), 400'(1234));

    linkEn = 1;
    curReq = "R3";
    runSeq(5, 10, 0);
    busRead(mkAddr(0, 0, 2), d); chk("R11 status done", 400'(d), 400'(2));
    checkRecords("R3");

    curReq = "R6";  // crosses the top address
    runSeq(60, 8, 0);
    checkRecords("R6");

    curReq = "R5";  // zero length
    runSeq(20, 0, 0);
    busRead(mkAddr(0, 0, 2), d); chk("R5 R11 status", 400'(d), 400'(2));
    checkRecords("R5");

    curReq = "R7";
    runSeq(10, 20, 5);
    checkRecords("R7");

    curReq = "R6";  // longer than the memory depth
    runSeq(3, 100, 0);
    checkRecords("R10");

    curReq = "R11";
    busWrite(mkAddr(0, 0, 1), 16'd6);
    busWrite(mkAddr(0, 0, 2), 16'd1);
    busRead(mkAddr(0, 0, 2), d); chk("R11 status busy", 400'(d), 400'(1));
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    linkEn = 0;
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule